// File: doc/BRIEF.md
# PLL Clock-Control Register File

This block is the software-visible register bank of a clock control unit. It holds PLL control words, bus divider settings, peripheral clock words, DRAM clock settings and a lock-control word. It does not generate, divide or gate any clock. It only stores what software programs and returns it on reads. A few fields behave differently from plain storage. A PLL word written with its enable bit set reads back as locked at once. Two update-request bits clear themselves. Accesses beyond the implemented window are refused.

Access is through a plain 32-bit, word-only register bus with select, write enable, address, write data, read data, ready and an error flag. Every access completes in one cycle. Read data and the error flag are registered, so they appear on the cycle after the address is presented. The low two address bits are ignored, and the word index is the byte address divided by four.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, these byte offsets read as follows:
  - 0x000 and 0x020 read 0x00001000.
  - 0x008 reads 0x00035514.
  - 0x010, 0x018, 0x030, 0x038 and 0x048 read 0x03006207.
  - 0x028 and 0x02C read 0x00041811.
  - 0x034 reads 0x00001811.
  - 0x040 reads 0x00000515.
  - 0x04C reads 0x00001800.
  - 0x054 reads 0x00001010.
  - 0x058 reads 0x01000000.
  - 0x0F0 reads 0x00000001.
  - 0x0F8 reads 0x0CCCA000.
  - 0x310 reads 0x0000000F.
  - Every other word below 0x324 reads 0.
- R2: A write to a PLL word with bit 31 (enable) set stores bit 28 (lock) as 1, and all other bits as written. The PLL words are at offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x02C, 0x030, 0x034, 0x038, 0x040, 0x048 and 0x04C.
- R3: A write to a PLL word with bit 31 clear stores bit 28 exactly as written.
- R4: A write to offset 0x04C always stores bit 30 as 0, and R2 also applies to it.
- R5: A write to offset 0x0F4 always stores bit 16 as 0.
- R6: A write to any other offset below 0x324 is stored exactly as written, including bit 28 when bit 31 is set.
- R7: A read at offset 0x324 or above returns 0, and the error flag is 1 on the cycle the data is returned.
- R8: A write at offset 0x324 or above changes no stored word, even when the address would alias a low word if its top bits were dropped. The error flag pulses for one cycle.
- R9: Ready is always 1. Read data for an address presented on one cycle appears after the next rising edge, and the read data output does not change before that edge.
- R10: While select is low, nothing is stored and the error flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Access complete (always 1) |
| bus_err | output | 1 | Registered access error (offset at or beyond window) |

## Verification
The hardest case to reach is an out-of-window write whose address, with its top bits cut off, would land on a live PLL word. For example, 0x400 truncated to the eight index bits becomes word 0. The bench writes 0x400 and 0xFFC with distinctive data and then reads word 0 and the last word, to show that neither changed. The lock and update-clear rules are driven through every PLL word with enable both set and clear, and with lock written both ways, so that forced and passed-through bits are told apart.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int unsigned EN_BIT       = 31;
   localparam int unsigned LOCK_BIT     = 28;
   localparam int unsigned PLL_UPD_BIT  = 30;
   localparam int unsigned DRAM_UPD_BIT = 16;

   typedef enum logic [1:0] {
      WK_PLAIN    = 2'd0,
      WK_PLL      = 2'd1,
      WK_PLL_UPD  = 2'd2,
      WK_DRAM_UPD = 2'd3
   } word_kind_e;

   // Classify a byte offset by the write rule it follows.
   function automatic word_kind_e kind_of(input int unsigned off);
      case (off)
         32'h000, 32'h008, 32'h010, 32'h018, 32'h020, 32'h028, 32'h02C,
         32'h030, 32'h034, 32'h038, 32'h040, 32'h048: return WK_PLL;
         32'h04C: return WK_PLL_UPD;
         32'h0F4: return WK_DRAM_UPD;
         default: return WK_PLAIN;
      endcase
   endfunction

   // Power-on value of the word at a byte offset.
   function automatic logic [31:0] reset_word(input int unsigned off);
      case (off)
         32'h000, 32'h020:                             return 32'h0000_1000;
         32'h008:                                      return 32'h0003_5514;
         32'h010, 32'h018, 32'h030, 32'h038, 32'h048:  return 32'h0300_6207;
         32'h028, 32'h02C:                             return 32'h0004_1811;
         32'h034:                                      return 32'h0000_1811;
         32'h040:                                      return 32'h0000_0515;
         32'h04C:                                      return 32'h0000_1800;
         32'h054:                                      return 32'h0000_1010;
         32'h058:                                      return 32'h0100_0000;
         32'h0F0:                                      return 32'h0000_0001;
         32'h0F8:                                      return 32'h0CCC_A000;
         32'h310:                                      return 32'h0000_000F;
         default:                                      return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/clkctl_wr_filter.sv
module clkctl_wr_filter
   import clkctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 8
) (
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] wr_val
);

   word_kind_e kind;

   always_comb begin
      kind   = kind_of(32'(wr_idx) * 4);
      wr_val = wr_data;
      case (kind)
         WK_PLL: begin
            if (wr_data[EN_BIT]) wr_val[LOCK_BIT] = 1'b1;
         end
         WK_PLL_UPD: begin
            wr_val[PLL_UPD_BIT] = 1'b0;
            if (wr_data[EN_BIT]) wr_val[LOCK_BIT] = 1'b1;
         end
         WK_DRAM_UPD: begin
            wr_val[DRAM_UPD_BIT] = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/clkctl_store.sv
module clkctl_store
   import clkctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 201,
   parameter int unsigned IDX_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_val,
   output logic [NWORDS-1:0][DATA_W-1:0] words
);

   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      localparam logic [DATA_W-1:0] INIT = DATA_W'(reset_word(g * 4));
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= INIT;
         else if (wr_en && (wr_idx == IDX_W'(g)))      q <= wr_val;
      end

      assign words[g] = q;
   end

endmodule

// File: rtl/clkctl_rd_port.sv
module clkctl_rd_port #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 201,
   parameter int unsigned IDX_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          acc,
   input  logic                          rd,
   input  logic                          in_range,
   input  logic [IDX_W-1:0]              idx,
   input  logic [NWORDS-1:0][DATA_W-1:0] words,
   output logic [DATA_W-1:0]             rdata,
   output logic                          err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         err <= acc && !in_range;
         if (rd) rdata <= in_range ? words[idx] : '0;
      end
   end

   // R7
   oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !in_range) |=> (rdata == '0) && err);

   // R10
   idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !err);

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
   import clkctl_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned WINDOW_BYTES = 32'h324
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              bus_err
);

   localparam int unsigned NWORDS = WINDOW_BYTES / 4;
   localparam int unsigned IDX_W  = $clog2(NWORDS);

   if (DATA_W != 32) begin : g_bad_width
      $error("clkctl_regbank: DATA_W must be 32");
   end
   if ((WINDOW_BYTES % 4) != 0 || WINDOW_BYTES > (1 << ADDR_W)) begin : g_bad_window
      $error("clkctl_regbank: window must be word aligned and fit the address");
   end

   logic [ADDR_W-1:0]              word_addr;
   logic                           in_range;
   logic [IDX_W-1:0]               w_idx;
   logic [DATA_W-1:0]              w_val;
   logic                           w_en;
   logic [NWORDS-1:0][DATA_W-1:0]  words;

   assign word_addr = ADDR_W'(bus_addr >> 2);
   assign in_range  = (32'(word_addr) < NWORDS);
   assign w_idx     = word_addr[IDX_W-1:0];
   assign w_en      = bus_sel && bus_we && in_range;
   assign bus_ready = 1'b1;

   clkctl_wr_filter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_filter (
      .wr_idx  (w_idx),
      .wr_data (bus_wdata),
      .wr_val  (w_val)
   );

   clkctl_store #(.DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (w_en),
      .wr_idx (w_idx),
      .wr_val (w_val),
      .words  (words)
   );

   clkctl_rd_port #(.DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (bus_sel),
      .rd       (bus_sel && !bus_we),
      .in_range (in_range),
      .idx      (w_idx),
      .words    (words),
      .rdata    (bus_rdata),
      .err      (bus_err)
   );

   // R2
   lock_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_en && bus_wdata[EN_BIT] &&
       (kind_of(32'(w_idx) * 4) inside {WK_PLL, WK_PLL_UPD}))
      |=> words[$past(w_idx)][LOCK_BIT]);

   // R4
   ddr_upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_en && (kind_of(32'(w_idx) * 4) == WK_PLL_UPD))
      |=> !words[$past(w_idx)][PLL_UPD_BIT]);

   // R5
   dram_upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_en && (kind_of(32'(w_idx) * 4) == WK_DRAM_UPD))
      |=> !words[$past(w_idx)][DRAM_UPD_BIT]);

   // R8
   oor_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && !in_range) |=> $stable(words) && bus_err);

   // R9
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && in_range) |=> bus_rdata == $past(words[w_idx]));

endmodule

// File: tb/tb_clkctl_regbank.sv
`timescale 1ns/1ps
module tb_clkctl_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ready;
   logic        err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   clkctl_regbank dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .bus_ready(ready), .bus_err(err)
   );

   function automatic logic [31:0] exp_default(input int unsigned off);
      case (off)
         32'h000, 32'h020: return 32'h0000_1000;
         32'h008: return 32'h0003_5514;
         32'h010, 32'h018, 32'h030, 32'h038, 32'h048: return 32'h0300_6207;
         32'h028, 32'h02C: return 32'h0004_1811;
         32'h034: return 32'h0000_1811;
         32'h040: return 32'h0000_0515;
         32'h04C: return 32'h0000_1800;
         32'h054: return 32'h0000_1010;
         32'h058: return 32'h0100_0000;
         32'h0F0: return 32'h0000_0001;
         32'h0F8: return 32'h0CCC_A000;
         32'h310: return 32'h0000_000F;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      e = err;
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      d = rdata; e = err;
      sel = 1'b0;
   endtask

   task automatic test_reset();
      logic [31:0] d; logic e;
      check("R9 ready after reset", 32'(ready), 32'd1);
      check("R10 err after reset", 32'(err), 32'd0);
      for (int i = 0; i < 32'h324; i += 4) begin
         bus_read(12'(i), d, e);
         check($sformatf("R1 default @%03h", i), d, exp_default(i));
         check("R7 no err in window", 32'(e), 32'd0);
      end
   endtask

   task automatic test_pll_lock();
      int unsigned plls[13] = '{32'h000, 32'h008, 32'h010, 32'h018, 32'h020, 32'h028,
                                32'h02C, 32'h030, 32'h034, 32'h038, 32'h040, 32'h048, 32'h04C};
      logic [31:0] d; logic e;
      foreach (plls[k]) begin
         bus_write(12'(plls[k]), 32'h8000_0123 | (k << 4), e);
         bus_read(12'(plls[k]), d, e);
         check($sformatf("R2 lock forced @%03h", plls[k]), d, 32'h9000_0123 | (k << 4));
         bus_write(12'(plls[k]), 32'h0000_0A5A, e);
         bus_read(12'(plls[k]), d, e);
         check($sformatf("R3 lock clear kept @%03h", plls[k]), d, 32'h0000_0A5A);
         bus_write(12'(plls[k]), 32'h1000_0A5A, e);
         bus_read(12'(plls[k]), d, e);
         check($sformatf("R3 lock set kept @%03h", plls[k]), d, 32'h1000_0A5A);
      end
   endtask

   task automatic test_upd_clear();
      logic [31:0] d; logic e;
      bus_write(12'h04C, 32'h4000_1234, e);
      bus_read(12'h04C, d, e);
      check("R4 ddr upd cleared", d, 32'h0000_1234);
      bus_write(12'h04C, 32'hC000_0077, e);
      bus_read(12'h04C, d, e);
      check("R4 ddr upd cleared with lock", d, 32'h9000_0077);
      bus_write(12'h0F4, 32'hFFFF_FFFF, e);
      bus_read(12'h0F4, d, e);
      check("R5 dram upd cleared", d, 32'hFFFE_FFFF);
      bus_write(12'h0F4, 32'h0001_0001, e);
      bus_read(12'h0F4, d, e);
      check("R5 dram upd cleared only", d, 32'h0000_0001);
   endtask

   task automatic test_plain();
      logic [31:0] d; logic e;
      bus_write(12'h054, 32'hA5A5_5A5A, e);
      bus_read(12'h054, d, e);
      check("R6 plain store", d, 32'hA5A5_5A5A);
      bus_write(12'h0F0, 32'h8000_0000, e);
      bus_read(12'h0F0, d, e);
      check("R6 no lock on plain word", d, 32'h8000_0000);
      bus_write(12'h320, 32'hC001_0000, e);
      check("R6 err on last word write", 32'(e), 32'd0);
      bus_read(12'h320, d, e);
      check("R6 last word stored", d, 32'hC001_0000);
   endtask

   task automatic test_out_of_range();
      logic [31:0] d; logic e;
      logic [31:0] w0;
      logic [31:0] wl;
      bus_read(12'h000, w0, e);
      bus_read(12'h320, wl, e);
      bus_read(12'h324, d, e);
      check("R7 read 0x324 data", d, 32'h0);
      check("R7 read 0x324 err", 32'(e), 32'd1);
      bus_read(12'hFFC, d, e);
      check("R7 read 0xFFC data", d, 32'h0);
      check("R7 read 0xFFC err", 32'(e), 32'd1);
      bus_write(12'h400, 32'hDEAD_BEEF, e);
      check("R8 write 0x400 err", 32'(e), 32'd1);
      @(negedge clk);
      check("R8 err one cycle", 32'(err), 32'd0);
      bus_write(12'hFFC, 32'h1234_5678, e);
      check("R8 write 0xFFC err", 32'(e), 32'd1);
      bus_read(12'h000, d, e);
      check("R8 no alias to word 0", d, w0);
      bus_read(12'h320, d, e);
      check("R8 last word unchanged", d, wl);
      bus_read(12'h324, d, e);
      check("R8 window edge still zero", d, 32'h0);
   endtask

   task automatic test_idle_and_timing();
      logic [31:0] d; logic e;
      bus_write(12'h058, 32'h0000_0042, e);
      @(negedge clk);
      sel = 1'b0; we = 1'b1; addr = 12'h058; wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R10 idle err", 32'(err), 32'd0);
      we = 1'b0;
      bus_read(12'h058, d, e);
      check("R10 idle write ignored", d, 32'h0000_0042);
      bus_read(12'h008, d, e);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = 12'h058;
      #3;
      check("R9 rdata before edge", rdata, d);
      check("R9 ready high", 32'(ready), 32'd1);
      @(negedge clk);
      check("R9 rdata after edge", rdata, 32'h0000_0042);
      sel = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_pll_lock();
      test_upd_clear();
      test_plain();
      test_out_of_range();
      test_idle_and_timing();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule